// File: doc/BRIEF.md
# NAND ID Geometry Probe Engine

This block sits on the controller side of a byte-wide NAND flash link and works out what device is attached. A single `start` pulse makes it drive a short command sequence through a strobe-and-acknowledge bus port. The sequence is a reset command, then a read-ID command with one zero address byte, then two ID reads. It looks the returned manufacturer and device bytes up in a small built-in table. When the matched table row leaves the page size or the erase size open, it reads three more ID bytes and decodes the geometry from the second of them.

On completion it raises `probeDone` for one cycle. The bus width, page size, erase-block size, address-cycle count and block count are then valid and hold until the next start. An unknown device, or a row with 256-byte pages, sets `probeErr` instead and drives all geometry outputs to zero.

The built-in table has twelve rows, searched in this order. Each row is given as manufacturer/device: page bytes, erase KiB, chip MiB, and "ext" means the value comes from the extended ID bytes.
- EC/D5: 8192, 1024, 2048
- any/6E: 256, 4, 1
- any/D5: 512, 8, 4
- any/73: 512, 16, 16
- any/76: 512, 16, 64
- any/59: 512, 8, 8, 16-bit
- any/E0: 512, 16, 16384
- any/F1: ext, ext, 128
- any/DA: ext, ext, 256
- any/C3: ext, ext, 1024, 16-bit
- any/48: ext, ext, 2048
- any/E1: ext, ext, 65536

Top module: `nand_id_probe`

## Requirements
- R1: After `start` the block issues, in order: a command strobe with byte 0xFF, a command strobe with byte 0x90, an address strobe with byte 0x00, and then read strobes. Each strobe is high for exactly one cycle, at most one strobe is high at a time, and no further strobe appears until `busAck` has answered the previous one.
- R2: Read data is taken from `busRdData` in the cycle `busAck` is high, and only bits [7:0] form the ID byte; bits above 7 have no effect on any output.
- R3: A table row matches when its device byte equals the second ID byte and its manufacturer byte equals the first ID byte or is zero. When several rows match, the first row in table order wins.
- R4: When the matched row has page size or erase size open, exactly three more reads follow the first two, making five. Otherwise, and when there is no match, exactly two reads are made.
- R5: With page size open, page bytes = 1024 << (fourth ID byte bits [1:0]).
- R6: With erase size open, erase KiB = 64 << (fourth ID byte bits [5:4]). This gives 64, 128, 256 or 512 KiB.
- R7: No match, or a resolved page size of 256 bytes, sets `probeErr`. In that case page, erase, cycles, blocks and width outputs are all zero.
- R8: For pages of 512 bytes or less, the address-cycle count is 3 for chips up to 32 MiB, 4 up to 8192 MiB, and 5 above that.
- R9: For pages above 512 bytes, the address-cycle count is 4 for chips up to 128 MiB, 5 up to 32768 MiB, and 6 above that.
- R10: Block count = chip MiB × 1024 / erase KiB.
- R11: `geoWide` is 1 exactly when the matched row is flagged 16-bit and no error is raised.
- R12: After reset, all outputs are zero. `probeDone` is a one-cycle pulse. The outputs stay unchanged from `probeDone` until the next accepted `start`, and a `start` that arrives while a probe is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for a probe |
| busCmd | output | 1 | Command strobe toward the flash interface |
| busAddr | output | 1 | Address strobe toward the flash interface |
| busRead | output | 1 | Data read strobe toward the flash interface |
| busByte | output | 8 | Command or address byte for the current strobe |
| busAck | input | 1 | Flash interface has completed the last strobe |
| busRdData | input | RD_W | Read word, valid while busAck is high |
| geoWide | output | 1 | 1 for a 16-bit device |
| geoPageBytes | output | 16 | Page size in bytes |
| geoEraseKib | output | 16 | Erase-block size in KiB |
| geoAddrCycles | output | 3 | Address cycles for a page address |
| geoBlocks | output | CNT_W | Erase blocks in the device |
| probeDone | output | 1 | One-cycle completion pulse |
| probeErr | output | 1 | Unknown or unsupported device |

## Verification
The bench walks every table row and sweeps all sixteen combinations of the page and erase fields in the fourth ID byte. It places junk in the upper read byte and in the unused ID bits, so a design that took the wrong byte or the wrong bits would report a wrong page or erase size. Shared device bytes are probed with a matching and a non-matching manufacturer. A design that kept the last match instead of the first, or ignored the wildcard, would return the other row's geometry. Rows sit just above and below each capacity threshold for both page classes, where an off-by-one comparison gives the wrong cycle count. A second start issued mid-probe would, in a design that accepted it, restart the sequence and add strobes.

// File: rtl/nand_probe_pkg.sv
package nand_probe_pkg;

  localparam int CHIP_W  = 17;
  localparam int TBL_N   = 12;

  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] CMD_READ_ID = 8'h90;
  localparam logic [7:0] ID_ADDR     = 8'h00;

  // sequence steps: 0 reset cmd, 1 id cmd, 2 address, 3..7 ID reads
  localparam logic [2:0] STEP_RST   = 3'd0;
  localparam logic [2:0] STEP_IDCMD = 3'd1;
  localparam logic [2:0] STEP_ADDR  = 3'd2;
  localparam logic [2:0] STEP_MFR   = 3'd3;
  localparam logic [2:0] STEP_DEV   = 3'd4;
  localparam logic [2:0] STEP_EXT3  = 3'd5;
  localparam logic [2:0] STEP_EXT4  = 3'd6;
  localparam logic [2:0] STEP_LAST  = 3'd7;

  // geometry held per table row; a log2 of zero marks a field taken from the extended ID
  typedef struct packed {
    logic              wide;
    logic [3:0]        pageLog;   // log2 of page bytes
    logic [3:0]        eraseLog;  // log2 of erase KiB
    logic [CHIP_W-1:0] chipMib;
  } geoT;

  typedef struct packed {
    logic [7:0] mfr;
    logic [7:0] dev;
    geoT        geo;
  } tblRowT;

  typedef struct packed {
    logic clrAll;
    logic capMfr;
    logic capDev;
    logic capExt;
    logic doLookup;
    logic doDecode;
  } strobeT;

  function automatic tblRowT rowAt(input int idx);
    tblRowT r;
    case (idx)
      0:       r = '{mfr: 8'hEC, dev: 8'hD5, geo: '{1'b0, 4'd13, 4'd10, 17'd2048}};
      1:       r = '{mfr: 8'h00, dev: 8'h6E, geo: '{1'b0, 4'd8,  4'd2,  17'd1}};
      2:       r = '{mfr: 8'h00, dev: 8'hD5, geo: '{1'b0, 4'd9,  4'd3,  17'd4}};
      3:       r = '{mfr: 8'h00, dev: 8'h73, geo: '{1'b0, 4'd9,  4'd4,  17'd16}};
      4:       r = '{mfr: 8'h00, dev: 8'h76, geo: '{1'b0, 4'd9,  4'd4,  17'd64}};
      5:       r = '{mfr: 8'h00, dev: 8'h59, geo: '{1'b1, 4'd9,  4'd3,  17'd8}};
      6:       r = '{mfr: 8'h00, dev: 8'hE0, geo: '{1'b0, 4'd9,  4'd4,  17'd16384}};
      7:       r = '{mfr: 8'h00, dev: 8'hF1, geo: '{1'b0, 4'd0,  4'd0,  17'd128}};
      8:       r = '{mfr: 8'h00, dev: 8'hDA, geo: '{1'b0, 4'd0,  4'd0,  17'd256}};
      9:       r = '{mfr: 8'h00, dev: 8'hC3, geo: '{1'b1, 4'd0,  4'd0,  17'd1024}};
      10:      r = '{mfr: 8'h00, dev: 8'h48, geo: '{1'b0, 4'd0,  4'd0,  17'd2048}};
      11:      r = '{mfr: 8'h00, dev: 8'hE1, geo: '{1'b0, 4'd0,  4'd0,  17'd65536}};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nand_probe_ctrl.sv
module nand_probe_ctrl
  import nand_probe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busAck,
  input  logic       needExt,
  output strobeT     stb,
  output logic       busCmd,
  output logic       busAddr,
  output logic       busRead,
  output logic [7:0] busByte,
  output logic       probeDone
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_LOOKUP, ST_DECODE
  } stateT;

  stateT      state;
  logic [2:0] step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      step      <= STEP_RST;
      probeDone <= 1'b0;
    end else begin
      probeDone <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          step  <= STEP_RST;
          state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (busAck) begin
          if (step == STEP_DEV)       state <= ST_LOOKUP;
          else if (step == STEP_LAST) state <= ST_DECODE;
          else begin
            step  <= step + 3'd1;
            state <= ST_ISSUE;
          end
        end
        ST_LOOKUP: begin
          if (needExt) begin
            step  <= STEP_EXT3;
            state <= ST_ISSUE;
          end else begin
            state <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          probeDone <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb     = '0;
    busCmd  = 1'b0;
    busAddr = 1'b0;
    busRead = 1'b0;
    busByte = 8'h00;
    case (state)
      ST_IDLE:   stb.clrAll = start;
      ST_ISSUE: begin
        case (step)
          STEP_RST:   begin busCmd  = 1'b1; busByte = CMD_RESET;   end
          STEP_IDCMD: begin busCmd  = 1'b1; busByte = CMD_READ_ID; end
          STEP_ADDR:  begin busAddr = 1'b1; busByte = ID_ADDR;     end
          default:    busRead = 1'b1;
        endcase
      end
      ST_WAIT: begin
        stb.capMfr = busAck && (step == STEP_MFR);
        stb.capDev = busAck && (step == STEP_DEV);
        stb.capExt = busAck && (step == STEP_EXT4);
      end
      ST_LOOKUP: stb.doLookup = 1'b1;
      ST_DECODE: stb.doDecode = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/nand_probe_dpath.sv
module nand_probe_dpath
  import nand_probe_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [7:0]       rdByte,
  output logic             needExt,
  output logic             geoWide,
  output logic [15:0]      geoPageBytes,
  output logic [15:0]      geoEraseKib,
  output logic [2:0]       geoAddrCycles,
  output logic [CNT_W-1:0] geoBlocks,
  output logic             probeErr
);

  localparam logic [CHIP_W-1:0] SMALL_LIM3 = CHIP_W'(32);
  localparam logic [CHIP_W-1:0] SMALL_LIM4 = CHIP_W'(8192);
  localparam logic [CHIP_W-1:0] LARGE_LIM4 = CHIP_W'(128);
  localparam logic [CHIP_W-1:0] LARGE_LIM5 = CHIP_W'(32768);

  logic [7:0] mfrQ, devQ;
  logic [1:0] extPageQ, extEraseQ;
  geoT        selQ;
  logic       selHitQ;

  // first-match search over the table
  geoT  hitGeo;
  logic found;
  always_comb begin
    hitGeo = '0;
    found  = 1'b0;
    for (int i = 0; i < TBL_N; i++) begin
      tblRowT row;
      row = rowAt(i);
      if (!found && row.dev == devQ && (row.mfr == mfrQ || row.mfr == 8'h00)) begin
        found  = 1'b1;
        hitGeo = row.geo;
      end
    end
  end

  assign needExt = found && (hitGeo.pageLog == 4'd0 || hitGeo.eraseLog == 4'd0);

  // geometry resolution from the latched row and extended bits
  logic [3:0]        pageLogD, eraseLogD;
  logic              errD, smallD;
  logic [2:0]        cyclesD;
  logic [CNT_W-1:0]  blocksD;

  always_comb begin
    pageLogD  = (selQ.pageLog == 4'd0) ? 4'd10 + {2'b00, extPageQ} : selQ.pageLog;
    eraseLogD = (selQ.eraseLog == 4'd0) ? 4'd6 + {2'b00, extEraseQ} : selQ.eraseLog;
    errD      = !selHitQ || (pageLogD == 4'd8);
    smallD    = (pageLogD <= 4'd9);
    if (smallD) begin
      if (selQ.chipMib <= SMALL_LIM3)      cyclesD = 3'd3;
      else if (selQ.chipMib <= SMALL_LIM4) cyclesD = 3'd4;
      else                                 cyclesD = 3'd5;
    end else begin
      if (selQ.chipMib <= LARGE_LIM4)      cyclesD = 3'd4;
      else if (selQ.chipMib <= LARGE_LIM5) cyclesD = 3'd5;
      else                                 cyclesD = 3'd6;
    end
    blocksD = CNT_W'(selQ.chipMib) << (4'd10 - eraseLogD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mfrQ <= '0; devQ <= '0; extPageQ <= '0; extEraseQ <= '0;
      selQ <= '0; selHitQ <= 1'b0;
    end else begin
      if (stb.clrAll) begin
        mfrQ <= '0; devQ <= '0; extPageQ <= '0; extEraseQ <= '0;
        selQ <= '0; selHitQ <= 1'b0;
      end
      if (stb.capMfr) mfrQ <= rdByte;
      if (stb.capDev) devQ <= rdByte;
      if (stb.capExt) begin
        extPageQ  <= rdByte[1:0];
        extEraseQ <= rdByte[5:4];
      end
      if (stb.doLookup) begin
        selQ    <= hitGeo;
        selHitQ <= found;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrAll) begin
      geoWide       <= 1'b0;
      geoPageBytes  <= '0;
      geoEraseKib   <= '0;
      geoAddrCycles <= '0;
      geoBlocks     <= '0;
      probeErr      <= 1'b0;
    end else if (stb.doDecode) begin
      probeErr <= errD;
      if (errD) begin
        geoWide       <= 1'b0;
        geoPageBytes  <= '0;
        geoEraseKib   <= '0;
        geoAddrCycles <= '0;
        geoBlocks     <= '0;
      end else begin
        geoWide       <= selQ.wide;
        geoPageBytes  <= 16'(1) << pageLogD;
        geoEraseKib   <= 16'(1) << eraseLogD;
        geoAddrCycles <= cyclesD;
        geoBlocks     <= blocksD;
      end
    end
  end

endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
  import nand_probe_pkg::*;
#(
  parameter int RD_W  = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busCmd,
  output logic             busAddr,
  output logic             busRead,
  output logic [7:0]       busByte,
  input  logic             busAck,
  input  logic [RD_W-1:0]  busRdData,
  output logic             geoWide,
  output logic [15:0]      geoPageBytes,
  output logic [15:0]      geoEraseKib,
  output logic [2:0]       geoAddrCycles,
  output logic [CNT_W-1:0] geoBlocks,
  output logic             probeDone,
  output logic             probeErr
);

  strobeT stb;
  logic   needExt;
  logic   unusedHi;

  // only the low byte of a read word carries ID information
  assign unusedHi = ^busRdData[RD_W-1:8];

  nand_probe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .busAck    (busAck),
    .needExt   (needExt),
    .stb       (stb),
    .busCmd    (busCmd),
    .busAddr   (busAddr),
    .busRead   (busRead),
    .busByte   (busByte),
    .probeDone (probeDone)
  );

  nand_probe_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .rdByte        (busRdData[7:0]),
    .needExt       (needExt),
    .geoWide       (geoWide),
    .geoPageBytes  (geoPageBytes),
    .geoEraseKib   (geoEraseKib),
    .geoAddrCycles (geoAddrCycles),
    .geoBlocks     (geoBlocks),
    .probeErr      (probeErr)
  );

endmodule

// File: rtl/nand_id_probe_chk.sv
module nand_id_probe_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busCmd,
  input logic             busAddr,
  input logic             busRead,
  input logic             geoWide,
  input logic [15:0]      geoPageBytes,
  input logic [15:0]      geoEraseKib,
  input logic [2:0]       geoAddrCycles,
  input logic [CNT_W-1:0] geoBlocks,
  input logic             probeDone,
  input logic             probeErr
);

  p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busCmd, busAddr, busRead}));

  p_strobe_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd || busAddr || busRead) |=> !(busCmd || busAddr || busRead));

  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    probeErr |-> (geoPageBytes == 16'd0 && geoEraseKib == 16'd0 &&
                  geoBlocks == '0 && geoAddrCycles == 3'd0 && !geoWide));

  p_cycles_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    (probeDone && !probeErr) |-> (geoAddrCycles >= 3'd3 && geoAddrCycles <= 3'd6));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    probeDone |=> !probeDone);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!probeDone && !$past(start)) |->
      ($stable(geoPageBytes) && $stable(geoEraseKib) && $stable(geoBlocks) &&
       $stable(geoAddrCycles) && $stable(geoWide) && $stable(probeErr)));

endmodule

bind nand_id_probe nand_id_probe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .start         (start),
  .busCmd        (busCmd),
  .busAddr       (busAddr),
  .busRead       (busRead),
  .geoWide       (geoWide),
  .geoPageBytes  (geoPageBytes),
  .geoEraseKib   (geoEraseKib),
  .geoAddrCycles (geoAddrCycles),
  .geoBlocks     (geoBlocks),
  .probeDone     (probeDone),
  .probeErr      (probeErr)
);

// File: tb/tb_nand_id_probe.sv
module tb_nand_id_probe;

  localparam int RD_W  = 16;
  localparam int CNT_W = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             busCmd, busAddr, busRead;
  logic [7:0]       busByte;
  logic             busAck = 1'b0;
  logic [RD_W-1:0]  busRdData = '0;
  logic             geoWide;
  logic [15:0]      geoPageBytes, geoEraseKib;
  logic [2:0]       geoAddrCycles;
  logic [CNT_W-1:0] geoBlocks;
  logic             probeDone, probeErr;

  always #10 clk = ~clk;

  nand_id_probe #(.RD_W(RD_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .busCmd(busCmd), .busAddr(busAddr), .busRead(busRead), .busByte(busByte),
    .busAck(busAck), .busRdData(busRdData),
    .geoWide(geoWide), .geoPageBytes(geoPageBytes), .geoEraseKib(geoEraseKib),
    .geoAddrCycles(geoAddrCycles), .geoBlocks(geoBlocks),
    .probeDone(probeDone), .probeErr(probeErr)
  );

  int checks = 0;
  int errors = 0;

  // flash model state
  int         ackDelay = 1;
  logic [7:0] rdSeq [0:4];
  int         rdIdx = 0;
  int         evCount = 0;
  int         strobeTotal = 0;
  logic [1:0] evKind [0:15];
  logic [7:0] evByte [0:15];

  task automatic chk(input logic ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // responder: acknowledges each strobe after ackDelay cycles
  initial begin
    forever begin
      @(negedge clk);
      busAck = 1'b0;
      if (busCmd || busAddr || busRead) begin
        if (evCount < 16) begin
          evKind[evCount] = busCmd ? 2'd1 : (busAddr ? 2'd2 : 2'd3);
          evByte[evCount] = busByte;
        end
        evCount++;
        for (int d = 0; d < ackDelay; d++) @(negedge clk);
        busAck = 1'b1;
        if (evKind[(evCount - 1) % 16] == 2'd3) begin
          busRdData = {8'hC3, (rdIdx < 5) ? rdSeq[rdIdx] : 8'hEE};
          rdIdx++;
        end else begin
          busRdData = 16'h7E7E;
        end
      end
    end
  end

  // independent strobe counter
  initial begin
    forever begin
      @(negedge clk);
      if (busCmd || busAddr || busRead) strobeTotal++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // specification table: mfr (0 = any), dev, wide, page bytes (0 = ext), erase KiB (0 = ext), chip MiB
  task automatic tbRow(input int i, output logic [7:0] m, output logic [7:0] d,
                       output int w, output int pg, output int er, output longint ch);
    case (i)
      0:  begin m = 8'hEC; d = 8'hD5; w = 0; pg = 8192; er = 1024; ch = 2048;  end
      1:  begin m = 8'h00; d = 8'h6E; w = 0; pg = 256;  er = 4;    ch = 1;     end
      2:  begin m = 8'h00; d = 8'hD5; w = 0; pg = 512;  er = 8;    ch = 4;     end
      3:  begin m = 8'h00; d = 8'h73; w = 0; pg = 512;  er = 16;   ch = 16;    end
      4:  begin m = 8'h00; d = 8'h76; w = 0; pg = 512;  er = 16;   ch = 64;    end
      5:  begin m = 8'h00; d = 8'h59; w = 1; pg = 512;  er = 8;    ch = 8;     end
      6:  begin m = 8'h00; d = 8'hE0; w = 0; pg = 512;  er = 16;   ch = 16384; end
      7:  begin m = 8'h00; d = 8'hF1; w = 0; pg = 0;    er = 0;    ch = 128;   end
      8:  begin m = 8'h00; d = 8'hDA; w = 0; pg = 0;    er = 0;    ch = 256;   end
      9:  begin m = 8'h00; d = 8'hC3; w = 1; pg = 0;    er = 0;    ch = 1024;  end
      10: begin m = 8'h00; d = 8'h48; w = 0; pg = 0;    er = 0;    ch = 2048;  end
      default: begin m = 8'h00; d = 8'hE1; w = 0; pg = 0; er = 0; ch = 65536; end
    endcase
  endtask

  task automatic runProbe(input logic [7:0] mfr, input logic [7:0] dev, input int hit,
                          input int w, input int pgT, input int erT, input longint chip,
                          input logic [7:0] e4, input int dly, input int midStart,
                          input string ctx);
    int pg, er, expReads, cyc, seen, ok;
    longint blk;
    logic err;
    logic [15:0] hPage, hErase;
    logic [CNT_W-1:0] hBlk;
    pg  = (pgT != 0) ? pgT : (1024 << e4[1:0]);
    er  = (erT != 0) ? erT : (64 << e4[5:4]);
    err = (hit == 0) || (pg == 256);
    expReads = (hit != 0 && (pgT == 0 || erT == 0)) ? 5 : 2;
    if (pg <= 512) cyc = (chip <= 32) ? 3 : ((chip <= 8192) ? 4 : 5);
    else           cyc = (chip <= 128) ? 4 : ((chip <= 32768) ? 5 : 6);
    blk = chip * 1024 / er;
    if (err) begin pg = 0; er = 0; cyc = 0; blk = 0; w = 0; end

    rdSeq[0] = mfr; rdSeq[1] = dev; rdSeq[2] = 8'hA5; rdSeq[3] = e4; rdSeq[4] = 8'h5A;
    rdIdx = 0; evCount = 0; strobeTotal = 0; ackDelay = dly;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midStart != 0) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    seen = 0;
    for (int t = 0; t < 400 && seen == 0; t++) begin
      if (probeDone) seen = 1; else @(negedge clk);
    end
    chk(seen == 1, {ctx, " R12 done pulse seen"}, seen, 1);
    ok = (evCount >= 5 && evKind[0] == 2'd1 && evByte[0] == 8'hFF &&
          evKind[1] == 2'd1 && evByte[1] == 8'h90 &&
          evKind[2] == 2'd2 && evByte[2] == 8'h00 &&
          evKind[3] == 2'd3 && evKind[4] == 2'd3);
    chk(ok == 1, {ctx, " R1 strobe order/bytes"}, ok, 1);
    chk(strobeTotal == evCount, {ctx, " R1 no strobe before ack"}, strobeTotal, evCount);
    chk(evCount - 3 == expReads, {ctx, " R4 read count"}, evCount - 3, expReads);
    chk(probeErr == err, {ctx, " R7 error flag"}, probeErr, err);
    chk(geoWide == w[0], {ctx, " R11 width"}, geoWide, w);
    chk(geoPageBytes == pg, {ctx, " R5 page bytes"}, geoPageBytes, pg);
    chk(geoEraseKib == er, {ctx, " R6 erase KiB"}, geoEraseKib, er);
    chk(geoAddrCycles == cyc, {ctx, (pg <= 512) ? " R8 addr cycles" : " R9 addr cycles"},
        geoAddrCycles, cyc);
    chk(geoBlocks == blk, {ctx, " R10 block count"}, geoBlocks, blk);
    hPage = geoPageBytes; hErase = geoEraseKib; hBlk = geoBlocks;
    @(negedge clk);
    chk(probeDone == 1'b0, {ctx, " R12 done one cycle"}, probeDone, 0);
    repeat (10) @(negedge clk);
    ok = (geoPageBytes == hPage && geoEraseKib == hErase && geoBlocks == hBlk);
    chk(ok == 1, {ctx, " R12 outputs held"}, ok, 1);
  endtask

  initial begin
    logic [7:0] m, d;
    int w, pg, er;
    longint ch;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(geoPageBytes == 0 && geoBlocks == 0 && !probeDone && !probeErr && !geoWide,
        "R12 reset outputs zero", geoPageBytes, 0);
    chk(strobeTotal == 0, "R12 no strobes when idle", strobeTotal, 0);

    // every table row, generic manufacturer unless the row names one
    for (int i = 0; i < 12; i++) begin
      tbRow(i, m, d, w, pg, er, ch);
      runProbe((m != 8'h00) ? m : 8'h2C, d, 1, w, pg, er, ch,
               8'((i * 37) | 8'hCC), 1 + (i % 3), 0,
               (i == 5 || i == 9) ? "R2 wide row" : "R3 table row");
    end

    // R3: same device byte, other manufacturer falls through to the wildcard row
    tbRow(2, m, d, w, pg, er, ch);
    runProbe(8'h98, 8'hD5, 1, w, pg, er, ch, 8'h00, 2, 0, "R3 wildcard fallthrough");
    tbRow(0, m, d, w, pg, er, ch);
    runProbe(8'hEC, 8'hD5, 1, w, pg, er, ch, 8'h00, 1, 0, "R3 first match");

    // R5/R6: full sweep of the extended page and erase fields, junk in other bits
    tbRow(7, m, d, w, pg, er, ch);
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 4; e++) begin
        runProbe(8'h01, d, 1, w, pg, er, ch,
                 {2'b11, 2'(e), 2'b11, 2'(p)}, 1 + ((p + e) % 3), 0, "R5 R6 ext sweep");
      end
    end

    // R7: unknown device, R4 only two reads
    runProbe(8'hEC, 8'h11, 0, 0, 0, 0, 0, 8'h00, 2, 0, "R7 unknown device");

    // R12: start while busy is ignored
    tbRow(9, m, d, w, pg, er, ch);
    runProbe(8'h2C, d, 1, w, pg, er, ch, 8'h31, 2, 1, "R12 start while busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule